// File: doc/BRIEF.md
# HDLC Receive Character Queue with Tagged Status

This block sits between a receive deserializer, which has already removed flags and stuffed bits and checked the frame CRC, and the logic that drains received characters. Each character arrives with its end-of-frame marker and CRC verdict. The block stores the character and those tags together in a single queue entry. Status is therefore never reported early or late: the end-of-frame, CRC-error and overrun flags describe exactly the character that the last read returned.

If the queue is full when a character arrives, that character is lost. The block then tags the newest stored character as both overrun and end of frame, so the reader sees a truncated frame that ends at a well-defined point. Every further character of that frame is dropped until the upstream logic signals the start of a new frame. A separate output shows whether the receiver is inside the contents of a frame.

Top module: `hrx_rx_fifo`

## Requirements
- R1: After a synchronous reset the queue is empty, `rd_data` is 0 and all three read flags and `in_frame` are 0.
- R2: Characters are returned in arrival order. The character appears on `rd_data` in the cycle after the clock edge that sampled `rd_req` high on a non-empty queue.
- R3: `rd_eof` is 1 exactly when the character just read was stored with `in_eof` high, or was later marked by an overrun.
- R4: `rd_crc_err` is 1 only for a character stored with both `in_eof` and `in_crc_bad` high. `in_crc_bad` on a character without `in_eof` has no effect, so `rd_crc_err` high always implies `rd_eof` high.
- R5: All three read flags are replaced on every successful read by the tags of that character.
- R6: A read of an empty queue sets `rd_data` to 0 and leaves `rd_eof`, `rd_crc_err` and `rd_overrun` unchanged.
- R7: A character that arrives while the queue holds DEPTH (16) entries is not stored. Instead the newest stored entry gets its overrun and end-of-frame tags set, and it is later read with `rd_overrun`=1 and `rd_eof`=1.
- R8: After an overrun, every arriving character is dropped until a cycle with `in_sof` high. A character presented in that same cycle is stored normally.
- R9: `in_frame` goes to 1 on the edge after `in_sof` and to 0 on the edge after a character with `in_eof`, whether or not that character is stored. If both occur in one cycle, the end of frame wins.
- R10: While `rx_en` is 0 the queue is emptied, all read outputs and `in_frame` are cleared, and arriving characters and reads are ignored.
- R11: `fifo_empty` and `fifo_full` reflect the entry count (0 and DEPTH) one edge after each write or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low clears and holds the block idle |
| in_valid | input | 1 | A deframed character is presented this cycle |
| in_data | input | 8 | Character value |
| in_eof | input | 1 | Character is the last of its frame |
| in_crc_bad | input | 1 | Frame CRC mismatched (meaningful with `in_eof`) |
| in_sof | input | 1 | Pulse: contents of a new frame begin |
| rd_req | input | 1 | Read one character |
| rd_data | output | 8 | Character returned by the last read |
| rd_eof | output | 1 | Last read character ended its frame |
| rd_crc_err | output | 1 | Last read character carried a CRC error |
| rd_overrun | output | 1 | Last read character was marked by an overrun |
| in_frame | output | 1 | Receiver is inside frame contents |
| fifo_empty | output | 1 | Queue holds no entries |
| fifo_full | output | 1 | Queue holds DEPTH entries |

## Verification
Every output of this block moves exactly one clock edge after the stimulus that causes it. A read request changes `rd_data` and the three flags on the next edge. A write or read changes the empty and full indications on the next edge. `in_sof` and an end-of-frame character change `in_frame` on the next edge. An overrun tag does not show up until the marked entry itself is read, possibly many cycles later. The bench holds a queue-based model that it advances on each rising edge from the same inputs. It compares every output on the following falling edge, so each result is checked in the cycle it is due. Directed sequences pin down the empty read, the overrun-and-resume order and the enable drop with literal expected values.

// File: rtl/hrx_pkg.sv
package hrx_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef logic [CHAR_W-1:0] char_t;

    // One queue slot: character plus the status that travels with it.
    typedef struct packed {
        logic  ovr;
        logic  crc;
        logic  eof;
        char_t data;
    } rx_entry_t;

    // A CRC verdict is only meaningful on the closing character.
    function automatic rx_entry_t make_entry(char_t d, logic last, logic crc_bad);
        rx_entry_t e;
        e.data = d;
        e.eof  = last;
        e.crc  = last & crc_bad;
        e.ovr  = 1'b0;
        return e;
    endfunction

    // Truncation: the entry becomes the end of its frame and records the loss.
    function automatic rx_entry_t tag_overrun(rx_entry_t e);
        rx_entry_t t;
        t     = e;
        t.ovr = 1'b1;
        t.eof = 1'b1;
        return t;
    endfunction

endpackage

// File: rtl/hrx_store.sv
module hrx_store
    import hrx_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      push,
    input  logic      pop,
    input  logic      mark,
    input  rx_entry_t wr_entry,
    output rx_entry_t head,
    output logic      empty,
    output logic      full
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    rx_entry_t      mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr, newest_ptr;
    logic [CW-1:0]  count;
    logic           do_push, do_pop;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign do_push    = push & ~full;
    assign do_pop     = pop & ~empty;
    assign newest_ptr = (wr_ptr == '0) ? LAST_IDX : wr_ptr - 1'b1;
    assign empty      = (count == '0);
    assign full       = (count == CW'(DEPTH));
    assign head       = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage carries no reset: pointers alone define validity.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wr_entry;
        end else if (mark && !empty) begin
            mem[newest_ptr] <= tag_overrun(mem[newest_ptr]);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R7
    AST_MARK_WHEN_FULL: assert property (@(posedge clk) disable iff (rst) mark |-> full); // R7
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH)); // R11
    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (rst || flush) (push && !pop) |=> !empty); // R11

endmodule

// File: rtl/hrx_admit.sv
module hrx_admit (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic in_valid,
    input  logic in_eof,
    input  logic in_sof,
    input  logic full,
    output logic push,
    output logic mark,
    output logic in_frame
);

    logic dropping;
    logic drop_now;
    logic accept;

    // A frame start ends a discard in the same cycle.
    assign drop_now = dropping & ~in_sof;
    assign accept   = en & in_valid & ~drop_now;
    assign push     = accept & ~full;
    assign mark     = accept & full;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            dropping <= 1'b0;
            in_frame <= 1'b0;
        end else begin
            if (mark)
                dropping <= 1'b1;
            else if (in_sof)
                dropping <= 1'b0;

            if (in_valid && in_eof)
                in_frame <= 1'b0;
            else if (in_sof)
                in_frame <= 1'b1;
        end
    end

    AST_OVR_STARTS_DROP: assert property (@(posedge clk) disable iff (rst) mark |=> dropping); // R8
    AST_DROP_BLOCKS: assert property (@(posedge clk) disable iff (rst) (dropping && !in_sof) |-> !(push || mark)); // R8
    AST_EOF_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst) (en && in_valid && in_eof) |=> !in_frame); // R9
    AST_SOF_OPENS_FRAME: assert property (@(posedge clk) disable iff (rst) (en && in_sof && !(in_valid && in_eof)) |=> in_frame); // R9

endmodule

// File: rtl/hrx_status.sv
module hrx_status
    import hrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      rd_req,
    input  logic      empty,
    input  rx_entry_t head,
    output logic      pop,
    output rx_entry_t shown
);

    assign pop = en & rd_req & ~empty;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            shown <= '0;
        end else if (rd_req) begin
            if (empty)
                shown.data <= '0;
            else
                shown <= head;
        end
    end

    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (en && rd_req && empty) |=> (shown.data == '0 && $stable(shown.eof) && $stable(shown.crc) && $stable(shown.ovr))); // R6
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en |=> (shown == '0)); // R10

endmodule

// File: rtl/hrx_rx_fifo.sv
module hrx_rx_fifo
    import hrx_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_eof,
    input  logic              in_crc_bad,
    input  logic              in_sof,
    input  logic              rd_req,
    output logic [CHAR_W-1:0] rd_data,
    output logic              rd_eof,
    output logic              rd_crc_err,
    output logic              rd_overrun,
    output logic              in_frame,
    output logic              fifo_empty,
    output logic              fifo_full
);

    logic      push, mark, pop;
    rx_entry_t head, shown;

    hrx_admit u_admit (
        .clk      (clk),
        .rst      (rst),
        .en       (rx_en),
        .in_valid (in_valid),
        .in_eof   (in_eof),
        .in_sof   (in_sof),
        .full     (fifo_full),
        .push     (push),
        .mark     (mark),
        .in_frame (in_frame)
    );

    hrx_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (~rx_en),
        .push     (push),
        .pop      (pop),
        .mark     (mark),
        .wr_entry (make_entry(in_data, in_eof, in_crc_bad)),
        .head     (head),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    hrx_status u_status (
        .clk    (clk),
        .rst    (rst),
        .en     (rx_en),
        .rd_req (rd_req),
        .empty  (fifo_empty),
        .head   (head),
        .pop    (pop),
        .shown  (shown)
    );

    assign rd_data    = shown.data;
    assign rd_eof     = shown.eof;
    assign rd_crc_err = shown.crc;
    assign rd_overrun = shown.ovr;

    AST_CRC_WITH_EOF: assert property (@(posedge clk) disable iff (rst) rd_crc_err |-> rd_eof); // R4
    AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (fifo_empty && !in_frame && rd_data == '0)); // R1

endmodule

// File: tb/hrx_rx_fifo_tb_top.sv
module hrx_rx_fifo_tb_top;

    localparam int DEPTH = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1, rx_en = 1'b1;
    logic       in_valid = 0, in_eof = 0, in_crc_bad = 0, in_sof = 0, rd_req = 0;
    logic [7:0] in_data = '0;
    logic [7:0] rd_data;
    logic       rd_eof, rd_crc_err, rd_overrun, in_frame, fifo_empty, fifo_full;

    hrx_rx_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .rx_en(rx_en), .in_valid(in_valid), .in_data(in_data),
        .in_eof(in_eof), .in_crc_bad(in_crc_bad), .in_sof(in_sof), .rd_req(rd_req),
        .rd_data(rd_data), .rd_eof(rd_eof), .rd_crc_err(rd_crc_err), .rd_overrun(rd_overrun),
        .in_frame(in_frame), .fifo_empty(fifo_empty), .fifo_full(fifo_full)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model: entry = {ovr, crc, eof, data}
    logic [10:0] q[$];
    logic [7:0]  m_data = 0;
    bit m_eof = 0, m_crc = 0, m_ovr = 0, m_drop = 0, m_inf = 0;

    always @(posedge clk) begin
        bit was_full, was_empty, ovr_now;
        logic [10:0] e;
        was_full  = (q.size() == DEPTH);
        was_empty = (q.size() == 0);
        ovr_now   = 0;
        if (rst || !rx_en) begin
            q.delete();
            m_data = 0; m_eof = 0; m_crc = 0; m_ovr = 0; m_drop = 0; m_inf = 0;
        end else begin
            if (rd_req) begin
                if (was_empty) m_data = 0;
                else begin
                    e = q.pop_front();
                    m_data = e[7:0]; m_eof = e[8]; m_crc = e[9]; m_ovr = e[10];
                end
            end
            if (in_valid && !(m_drop && !in_sof)) begin
                if (was_full) begin
                    e = q[$];
                    e[8] = 1'b1; e[10] = 1'b1;
                    q[q.size()-1] = e;
                    ovr_now = 1;
                end else
                    q.push_back({1'b0, in_eof & in_crc_bad, in_eof, in_data});
            end
            if (ovr_now) m_drop = 1;
            else if (in_sof) m_drop = 0;
            if (in_valid && in_eof) m_inf = 0;
            else if (in_sof) m_inf = 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check("R2 data order", rd_data, m_data);
        check("R3 eof tag", rd_eof, m_eof);
        check("R4 crc tag", rd_crc_err, m_crc);
        check("R7 overrun tag", rd_overrun, m_ovr);
        check("R9 in_frame", in_frame, m_inf);
        check("R11 empty", fifo_empty, q.size() == 0);
        check("R11 full", fifo_full, q.size() == DEPTH);
    endtask

    task automatic put(input logic [7:0] d, input bit eof, input bit crc, input bit sof);
        in_valid = 1; in_data = d; in_eof = eof; in_crc_bad = crc; in_sof = sof;
        tick();
        in_valid = 0; in_eof = 0; in_crc_bad = 0; in_sof = 0;
    endtask

    task automatic rd();
        rd_req = 1;
        tick();
        rd_req = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        tick();
        // R1 reset state
        check("R1 reset data", rd_data, 0);
        check("R1 reset empty", fifo_empty, 1);
        check("R1 reset flags", {rd_eof, rd_crc_err, rd_overrun, in_frame}, 0);

        // Two frames; the CRC flag on a non-final character is ignored (R4)
        put(8'h11, 0, 0, 1); put(8'h22, 0, 0, 0); put(8'h33, 1, 0, 0);
        put(8'h44, 0, 1, 1); put(8'h55, 1, 1, 0);
        rd(); check("R2 first char", rd_data, 8'h11);
        rd(); rd(); check("R3 eof on 33", rd_eof, 1);
        rd(); check("R4 crc ignored on 44", rd_crc_err, 0);
        check("R5 eof replaced on read", rd_eof, 0);
        rd(); check("R4 crc on 55", rd_crc_err, 1);
        // R6 empty read
        rd(); check("R6 empty data", rd_data, 0);
        check("R6 flags kept", {rd_eof, rd_crc_err, rd_overrun}, 3'b110);

        // R7 overrun: 20 characters into a 16-deep queue
        for (int i = 0; i < 20; i++) put(8'h80 + 8'(i), i == 19, 0, i == 0);
        check("R11 full after overrun", fifo_full, 1);
        rd(); rd(); rd();
        put(8'h99, 1, 0, 0);                       // R8 still dropping
        put(8'hA0, 0, 0, 1); put(8'hA1, 1, 0, 0);  // R8 resumes with sof
        for (int i = 0; i < 13; i++) rd();
        check("R7 last valid char", rd_data, 8'h8F);
        check("R7 overrun+eof", {rd_overrun, rd_eof}, 2'b11);
        rd(); check("R8 resumed frame", rd_data, 8'hA0);
        check("R8 no overrun", rd_overrun, 0);
        rd(); rd();

        // R10 disable clears and ignores input
        put(8'h61, 0, 0, 1); put(8'h62, 1, 1, 0); rd();
        rx_en = 0;
        put(8'h63, 1, 0, 1);
        check("R10 cleared data", rd_data, 0);
        check("R10 cleared empty", fifo_empty, 1);
        rx_en = 1;
        tick();
        check("R10 input ignored", fifo_empty, 1);

        // Mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int phase;
            phase = (i / 250) % 3;
            in_valid   = ($urandom % 4) < ((phase == 0) ? 3 : 2);
            in_data    = 8'($urandom);
            in_eof     = ($urandom % 6) == 0;
            in_crc_bad = ($urandom % 2) == 0;
            in_sof     = ($urandom % 8) == 0;
            rd_req     = ($urandom % 4) < ((phase == 0) ? 1 : (phase == 1 ? 2 : 3));
            rx_en      = ($urandom % 500) != 0;
            tick();
        end
        in_valid = 0; in_eof = 0; in_crc_bad = 0; in_sof = 0; rd_req = 0; rx_en = 1;
        tick();

        done = 1;
        summary();
        $finish;
    end

endmodule